// File: doc/BRIEF.md
# Memory Bank Decode and Strobe Control

This block sits at the front of a multi-bank memory controller. When a bus transaction starts, it compares the address with every bank's base address under that bank's own address mask. The lowest-numbered valid bank that matches is selected. If that bank is controlled internally, the block runs a short state machine. It drives the bank's chip select, an address acknowledge, an address-latch pulse for an external address latch, and a single-cycle transfer acknowledge after a programmable delay.

A bank can be handed to an external controller or slave. For such a bank the block drives no chip select, latch pulse, acknowledge or parity select. It raises an external-bank flag until the external agent reports completion. An externally controlled bank is always placed on the system bus. When the initiator is an internal master, the bank's attributes (port size, data check, atomic lock, pipelining) are still presented to the rest of the controller, whichever agent owns the strobes.

A parity byte-select output is the AND of the active-low byte selects. It drives an ECC or parity memory device without external gating and is enabled by a configuration input.

The state machine has five states. ST_IDLE waits for a start. ST_ADDR is the first strobe cycle. ST_DATA covers the wait cycles. ST_ACK is the transfer-acknowledge cycle. ST_EXT covers an externally controlled access. The transitions are:
- ST_IDLE to ST_ADDR: start with an internal hit.
- ST_IDLE to ST_EXT: start with an external hit.
- ST_IDLE stays in ST_IDLE: no start, or a miss.
- ST_ADDR or ST_DATA to ST_ACK: the delay counter reaches one.
- ST_ADDR or ST_DATA to ST_DATA: the counter is still above one.
- ST_ACK to ST_IDLE: always.
- ST_EXT to ST_IDLE: on `ext_done`.
- ST_EXT stays in ST_EXT: until `ext_done`.

Top module: `bank_strobe_ctrl`

## Requirements
- R1: A bank matches when its valid bit is 1 and `((addr ^ base) & mask) == 0`. Of the matching banks, the lowest index wins. For an internal bank, `cs_n[bank]` goes low in the cycle after the one in which `xact_start` is sampled high.
- R2: At most one `cs_n` bit is low at any time. All `cs_n` bits are high during reset and while idle.
- R3: `ale_n` is low for exactly one cycle, the first cycle with a chip select low. It goes low only if `compat_mode` was 1 at start and the bank's system-bus bit (`cfg_sys`) is 1. Otherwise it stays high.
- R4: `aack` is high for exactly one cycle, the first chip-select cycle of an internal bank.
- R5: `ta` and `dval` are high together for one cycle, D cycles after the first chip-select cycle. D is `cfg_ack_dly` sampled at start, with 0 treated as 1. The chip select stays low through that cycle and goes high in the next.
- R6: For a bank whose `cfg_ext` bit is 1, `cs_n`, `ale_n` and `par_bs_n` stay high and `aack`, `ta` and `dval` stay low. `ext_bank` is high from the cycle after start until the cycle after `ext_done` is sampled high.
- R7: `sys_bus` is high during a transaction when the bank's `cfg_sys` bit or `cfg_ext` bit is 1, and low when idle.
- R8: During a transaction started with `init_internal = 1`, `attr_vld` is 1 and `attr_out` equals the bank's attribute field. This holds for external banks too. Otherwise `attr_vld` and `attr_out` are 0.
- R9: During an internal bank's strobe cycles, `par_bs_n` is the AND of the byte selects latched at start (low if any lane is low), provided `par_sel_en` was 1 at start. At all other times it is high.
- R10: A `xact_start` received while a transaction is in progress is ignored.
- R11: A start whose address matches no valid bank produces no strobe, acknowledge or flag, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| xact_start | input | 1 | Transaction start, sampled in idle |
| xact_addr | input | ADDR_W | Transaction address |
| init_internal | input | 1 | Initiator is an internal master |
| byte_sel_n | input | BS_W | Active-low byte-lane selects |
| compat_mode | input | 1 | Compatible-mode flag, enables the latch pulse |
| par_sel_en | input | 1 | Enables the parity byte select |
| ext_done | input | 1 | External agent has finished an external-bank access |
| cfg_valid | input | NUM_BANKS | Per-bank valid bit |
| cfg_ext | input | NUM_BANKS | Per-bank external-controller bit |
| cfg_sys | input | NUM_BANKS | Per-bank system-bus assignment bit |
| cfg_base | input | NUM_BANKS*ADDR_W | Packed base addresses, bank 0 in the low bits |
| cfg_mask | input | NUM_BANKS*ADDR_W | Packed address masks |
| cfg_attr | input | NUM_BANKS*ATTR_W | Packed bank attributes |
| cfg_ack_dly | input | DLY_W | Cycles from first chip select to transfer acknowledge |
| cs_n | output | NUM_BANKS | Active-low chip selects |
| ale_n | output | 1 | Active-low address-latch pulse |
| aack | output | 1 | Address acknowledge |
| ta | output | 1 | Transfer acknowledge |
| dval | output | 1 | Data valid |
| par_bs_n | output | 1 | Active-low parity byte select |
| ext_bank | output | 1 | Externally controlled access in progress |
| sys_bus | output | 1 | Current bank is on the system bus |
| attr_vld | output | 1 | Bank attributes apply |
| attr_out | output | ATTR_W | Attributes of the selected bank |

## Verification
The bench builds the block with four banks, a 16-bit address, 5-bit attributes and a 3-bit delay field. Four banks are enough for overlapping windows that test priority, one external bank, and one bank that starts invalid and is enabled later. The 3-bit delay covers the zero-as-one case, a one-cycle acknowledge and the maximum of seven cycles. The 16-bit address keeps every base and mask pattern readable.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_DATA = 3'd2,
        ST_ACK  = 3'd3,
        ST_EXT  = 3'd4
    } bsc_state_e;

endpackage

// File: rtl/bsc_bank_match.sv
module bsc_bank_match #(
    parameter int ADDR_W = 32
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [ADDR_W-1:0] diff;

    always_comb begin
        diff = (addr ^ base) & mask;
        hit  = valid && (diff == '0);
    end

endmodule

// File: rtl/bsc_prio_sel.sv
module bsc_prio_sel #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);

    // Scan from the top so the lowest requesting index is written last.
    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any      = 1'b1;
                idx      = IDX_W'(i);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bsc_fsm.sv
module bsc_fsm
    import bsc_pkg::*;
#(
    parameter int N      = 4,
    parameter int IDX_W  = 2,
    parameter int ATTR_W = 5,
    parameter int BS_W   = 8,
    parameter int DLY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hit_any,
    input  logic [IDX_W-1:0]  hit_idx,
    input  logic              hit_ext,
    input  logic              hit_sys,
    input  logic [ATTR_W-1:0] hit_attr,
    input  logic              internal,
    input  logic [BS_W-1:0]   byte_sel_n,
    input  logic              compat,
    input  logic              par_en,
    input  logic [DLY_W-1:0]  ack_dly,
    input  logic              ext_done,
    output logic [N-1:0]      cs_n,
    output logic              ale_n,
    output logic              aack,
    output logic              ta,
    output logic              dval,
    output logic              par_bs_n,
    output logic              ext_bank,
    output logic              sys_bus,
    output logic              attr_vld,
    output logic [ATTR_W-1:0] attr_out
);

    localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

    bsc_state_e        state_q, state_d;
    logic [DLY_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  bank_q;
    logic              ale_q;
    logic              sys_q;
    logic              int_q;
    logic              par_q;
    logic [ATTR_W-1:0] attr_q;
    logic [BS_W-1:0]   bs_q;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && start && hit_any;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = hit_ext ? ST_EXT : ST_ADDR;
                end
            end
            ST_ADDR, ST_DATA: begin
                state_d = (cnt_q <= DLY_ONE) ? ST_ACK : ST_DATA;
            end
            ST_ACK: begin
                state_d = ST_IDLE;
            end
            ST_EXT: begin
                if (ext_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Per-transaction context and delay counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bank_q <= '0;
            ale_q  <= 1'b0;
            sys_q  <= 1'b0;
            int_q  <= 1'b0;
            par_q  <= 1'b0;
            attr_q <= '0;
            bs_q   <= '1;
        end else if (accept) begin
            cnt_q  <= (ack_dly == '0) ? DLY_ONE : ack_dly;
            bank_q <= hit_idx;
            ale_q  <= compat && hit_sys && !hit_ext;
            sys_q  <= hit_sys;
            int_q  <= internal;
            par_q  <= par_en;
            attr_q <= hit_attr;
            bs_q   <= byte_sel_n;
        end else if ((state_q == ST_ADDR) || (state_q == ST_DATA)) begin
            cnt_q <= cnt_q - DLY_ONE;
        end
    end

    // Output decode
    always_comb begin
        cs_n     = '1;
        ale_n    = 1'b1;
        aack     = 1'b0;
        ta       = 1'b0;
        dval     = 1'b0;
        par_bs_n = 1'b1;
        ext_bank = 1'b0;
        sys_bus  = 1'b0;
        attr_vld = 1'b0;
        attr_out = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ADDR: begin
                cs_n[bank_q] = 1'b0;
                ale_n        = !ale_q;
                aack         = 1'b1;
                par_bs_n     = par_q ? (&bs_q) : 1'b1;
            end
            ST_DATA: begin
                cs_n[bank_q] = 1'b0;
                par_bs_n     = par_q ? (&bs_q) : 1'b1;
            end
            ST_ACK: begin
                cs_n[bank_q] = 1'b0;
                ta           = 1'b1;
                dval         = 1'b1;
                par_bs_n     = par_q ? (&bs_q) : 1'b1;
            end
            ST_EXT: begin
                ext_bank = 1'b1;
            end
            default: begin
            end
        endcase
        if (state_q != ST_IDLE) begin
            sys_bus  = sys_q;
            attr_vld = int_q;
            attr_out = int_q ? attr_q : '0;
        end
    end

endmodule

// File: rtl/bank_strobe_ctrl.sv
module bank_strobe_ctrl
    import bsc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 32,
    parameter int ATTR_W    = 5,
    parameter int BS_W      = 8,
    parameter int DLY_W     = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          xact_start,
    input  logic [ADDR_W-1:0]             xact_addr,
    input  logic                          init_internal,
    input  logic [BS_W-1:0]               byte_sel_n,
    input  logic                          compat_mode,
    input  logic                          par_sel_en,
    input  logic                          ext_done,
    input  logic [NUM_BANKS-1:0]          cfg_valid,
    input  logic [NUM_BANKS-1:0]          cfg_ext,
    input  logic [NUM_BANKS-1:0]          cfg_sys,
    input  logic [NUM_BANKS*ADDR_W-1:0]   cfg_base,
    input  logic [NUM_BANKS*ADDR_W-1:0]   cfg_mask,
    input  logic [NUM_BANKS*ATTR_W-1:0]   cfg_attr,
    input  logic [DLY_W-1:0]              cfg_ack_dly,
    output logic [NUM_BANKS-1:0]          cs_n,
    output logic                          ale_n,
    output logic                          aack,
    output logic                          ta,
    output logic                          dval,
    output logic                          par_bs_n,
    output logic                          ext_bank,
    output logic                          sys_bus,
    output logic                          attr_vld,
    output logic [ATTR_W-1:0]             attr_out
);

    localparam int IDX_W = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS);

    logic [NUM_BANKS-1:0] bank_hit;
    logic [NUM_BANKS-1:0] grant;
    logic [IDX_W-1:0]     win_idx;
    logic                 win_any;
    logic                 win_ext;
    logic                 win_sys;
    logic [ATTR_W-1:0]    win_attr;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bsc_bank_match #(.ADDR_W(ADDR_W)) u_match (
            .valid (cfg_valid[b]),
            .base  (cfg_base[b*ADDR_W +: ADDR_W]),
            .mask  (cfg_mask[b*ADDR_W +: ADDR_W]),
            .addr  (xact_addr),
            .hit   (bank_hit[b])
        );
    end

    bsc_prio_sel #(.N(NUM_BANKS), .IDX_W(IDX_W)) u_prio (
        .req   (bank_hit),
        .any   (win_any),
        .idx   (win_idx),
        .grant (grant)
    );

    // One-hot selection of the winning bank's properties.
    // An external bank is forced onto the system bus.
    always_comb begin
        win_ext  = |(grant & cfg_ext);
        win_sys  = |(grant & (cfg_sys | cfg_ext));
        win_attr = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (grant[i]) begin
                win_attr = win_attr | cfg_attr[i*ATTR_W +: ATTR_W];
            end
        end
    end

    bsc_fsm #(
        .N      (NUM_BANKS),
        .IDX_W  (IDX_W),
        .ATTR_W (ATTR_W),
        .BS_W   (BS_W),
        .DLY_W  (DLY_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (xact_start),
        .hit_any    (win_any),
        .hit_idx    (win_idx),
        .hit_ext    (win_ext),
        .hit_sys    (win_sys),
        .hit_attr   (win_attr),
        .internal   (init_internal),
        .byte_sel_n (byte_sel_n),
        .compat     (compat_mode),
        .par_en     (par_sel_en),
        .ack_dly    (cfg_ack_dly),
        .ext_done   (ext_done),
        .cs_n       (cs_n),
        .ale_n      (ale_n),
        .aack       (aack),
        .ta         (ta),
        .dval       (dval),
        .par_bs_n   (par_bs_n),
        .ext_bank   (ext_bank),
        .sys_bus    (sys_bus),
        .attr_vld   (attr_vld),
        .attr_out   (attr_out)
    );

endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
    parameter int NUM_BANKS = 4,
    parameter int ATTR_W    = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ext_done,
    input logic [NUM_BANKS-1:0] cs_n,
    input logic                 ale_n,
    input logic                 aack,
    input logic                 ta,
    input logic                 dval,
    input logic                 par_bs_n,
    input logic                 ext_bank,
    input logic                 sys_bus,
    input logic                 attr_vld,
    input logic [ATTR_W-1:0]    attr_out
);

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R3
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_n |=> ale_n);

    // R3
    ale_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_n |-> (cs_n != '1) && aack);

    // R4
    aack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aack |=> !aack);

    // R5
    ta_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ta |-> (cs_n != '1) && dval);

    // R5
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ta |=> (cs_n == '1));

    // R6
    ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_bank |-> (cs_n == '1) && ale_n && !aack && !ta && !dval && par_bs_n);

    // R6
    ext_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_bank && ext_done) |=> !ext_bank);

    // R7
    ext_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_bank |-> sys_bus);

    // R8
    attr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !attr_vld |-> (attr_out == '0));

    // R9
    par_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_bs_n |-> (cs_n != '1));

endmodule

bind bank_strobe_ctrl bsc_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ATTR_W    (ATTR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_done (ext_done),
    .cs_n     (cs_n),
    .ale_n    (ale_n),
    .aack     (aack),
    .ta       (ta),
    .dval     (dval),
    .par_bs_n (par_bs_n),
    .ext_bank (ext_bank),
    .sys_bus  (sys_bus),
    .attr_vld (attr_vld),
    .attr_out (attr_out)
);

// File: tb/sim_bank_strobe_ctrl.sv
module sim_bank_strobe_ctrl;

    localparam int NB = 4;
    localparam int AW = 16;
    localparam int AT = 5;
    localparam int BW = 8;
    localparam int DW = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          xact_start = 1'b0;
    logic [AW-1:0] xact_addr = '0;
    logic          init_internal = 1'b0;
    logic [BW-1:0] byte_sel_n = '1;
    logic          compat_mode = 1'b0;
    logic          par_sel_en = 1'b0;
    logic          ext_done = 1'b0;
    logic [DW-1:0] cfg_ack_dly = '0;
    logic [NB-1:0] v_valid = '0;
    logic [NB-1:0] v_ext = '0;
    logic [NB-1:0] v_sys = '0;
    logic [AW-1:0] v_base [NB];
    logic [AW-1:0] v_mask [NB];
    logic [AT-1:0] v_attr [NB];
    logic [NB*AW-1:0] cfg_base, cfg_mask;
    logic [NB*AT-1:0] cfg_attr;

    logic [NB-1:0] cs_n;
    logic          ale_n, aack, ta, dval, par_bs_n, ext_bank, sys_bus, attr_vld;
    logic [AT-1:0] attr_out;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            cfg_base[i*AW +: AW] = v_base[i];
            cfg_mask[i*AW +: AW] = v_mask[i];
            cfg_attr[i*AT +: AT] = v_attr[i];
        end
    end

    bank_strobe_ctrl #(
        .NUM_BANKS(NB), .ADDR_W(AW), .ATTR_W(AT), .BS_W(BW), .DLY_W(DW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .xact_start(xact_start), .xact_addr(xact_addr),
        .init_internal(init_internal), .byte_sel_n(byte_sel_n),
        .compat_mode(compat_mode), .par_sel_en(par_sel_en), .ext_done(ext_done),
        .cfg_valid(v_valid), .cfg_ext(v_ext), .cfg_sys(v_sys),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_attr(cfg_attr),
        .cfg_ack_dly(cfg_ack_dly), .cs_n(cs_n), .ale_n(ale_n), .aack(aack),
        .ta(ta), .dval(dval), .par_bs_n(par_bs_n), .ext_bank(ext_bank),
        .sys_bus(sys_bus), .attr_vld(attr_vld), .attr_out(attr_out)
    );

    typedef struct {
        bit            ext;
        int            bank;
        bit            ale;
        bit            par_n;
        bit            sys;
        bit            vld;
        logic [AT-1:0] attr;
        int            dly;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   n_push = 0;
    int   n_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference decode from R1
    function automatic int ref_bank(input logic [AW-1:0] a);
        for (int i = 0; i < NB; i++) begin
            if (v_valid[i] && (((a ^ v_base[i]) & v_mask[i]) == '0)) return i;
        end
        return -1;
    endfunction

    // Driver: pushes the expected item and runs one transaction.
    // busy_poke issues a second start inside the transaction (R10).
    task automatic do_xact(input logic [AW-1:0] a, input logic [BW-1:0] bs,
                           input bit intm, input int dly, input bit busy_poke);
        int   b;
        int   eff;
        exp_t e;
        b   = ref_bank(a);
        eff = (dly == 0) ? 1 : dly;
        if (b >= 0) begin
            e.ext   = v_ext[b];
            e.bank  = b;
            e.sys   = v_sys[b] | v_ext[b];
            e.ale   = compat_mode && v_sys[b] && !v_ext[b];
            e.par_n = (par_sel_en && !v_ext[b]) ? (&bs) : 1'b1;
            e.vld   = intm;
            e.attr  = intm ? v_attr[b] : '0;
            e.dly   = eff;
            q.push_back(e);
            n_push++;
        end
        @(posedge clk); #2;
        xact_addr     = a;
        byte_sel_n    = bs;
        init_internal = intm;
        cfg_ack_dly   = DW'(dly);
        xact_start    = 1'b1;
        @(posedge clk); #2;
        xact_start = 1'b0;
        if (busy_poke) begin
            @(posedge clk); #2;
            xact_start = 1'b1;
            @(posedge clk); #2;
            xact_start = 1'b0;
        end
        if (b >= 0 && v_ext[b]) begin
            repeat (3) @(posedge clk);
            #2 ext_done = 1'b1;
            @(posedge clk); #2;
            ext_done = 1'b0;
        end
        repeat (eff + 3) @(posedge clk);
    endtask

    // Monitor / scoreboard
    bit   in_int = 0, rel_pend = 0, ext_prev = 0, quiet_bad = 0, ale_bad = 0;
    int   cyc = 0;
    exp_t cur;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rel_pend) begin
                chk(cs_n == '1, "R5", "cs released after ta", cs_n, '1);
                chk(!ale_bad, "R3", "ale_n single cycle", ale_bad, 0);
                rel_pend = 0;
            end
            if (!in_int && cs_n != '1) begin
                n_seen++;
                if (q.size() == 0) begin
                    chk(0, "R10", "unexpected transaction", cs_n, '1);
                    cur.dly = 1; cur.bank = 0; cur.ext = 0;
                end else begin
                    cur = q.pop_front();
                    chk(!cur.ext, "R6", "internal strobes on external bank", 1, 0);
                    chk(cs_n == ~(NB'(1) << cur.bank), "R1", "cs_n decode", cs_n, ~(NB'(1) << cur.bank));
                    chk(ale_n == !cur.ale, "R3", "ale_n first cycle", ale_n, !cur.ale);
                    chk(aack == 1'b1, "R4", "aack first cycle", aack, 1);
                    chk(par_bs_n == cur.par_n, "R9", "par_bs_n", par_bs_n, cur.par_n);
                    chk(sys_bus == cur.sys, "R7", "sys_bus", sys_bus, cur.sys);
                    chk(attr_vld == cur.vld && attr_out == cur.attr, "R8", "attributes",
                        {attr_vld, attr_out}, {cur.vld, cur.attr});
                end
                in_int = 1; cyc = 0; ale_bad = 0;
            end else if (in_int) begin
                cyc++;
                if (!ale_n || aack) ale_bad = 1;
                if (ta) begin
                    chk(cyc == cur.dly, "R5", "ta delay", cyc, cur.dly);
                    chk(dval == 1'b1, "R5", "dval with ta", dval, 1);
                    chk(cs_n == ~(NB'(1) << cur.bank), "R5", "cs held at ta", cs_n, ~(NB'(1) << cur.bank));
                    in_int = 0; rel_pend = 1;
                end
            end else if (ta || aack) begin
                chk(0, "R4", "acknowledge outside transaction", {ta, aack}, 0);
            end
            if (ext_bank && !ext_prev) begin
                n_seen++;
                quiet_bad = 0;
                if (q.size() == 0) begin
                    chk(0, "R10", "unexpected external access", 1, 0);
                end else begin
                    cur = q.pop_front();
                    chk(cur.ext, "R6", "external flag on internal bank", 0, 1);
                    chk(sys_bus == 1'b1, "R7", "external bank on system bus", sys_bus, 1);
                    chk(attr_vld == cur.vld && attr_out == cur.attr, "R8", "external attributes",
                        {attr_vld, attr_out}, {cur.vld, cur.attr});
                end
            end
            if (ext_bank && (cs_n != '1 || !ale_n || aack || ta || dval || !par_bs_n))
                quiet_bad = 1;
            if (!ext_bank && ext_prev)
                chk(!quiet_bad, "R6", "external bank strobes quiet", quiet_bad, 0);
            ext_prev = ext_bank;
        end
    end

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        v_base[0] = 16'h1000; v_mask[0] = 16'hF000; v_attr[0] = 5'h03;
        v_base[1] = 16'h1200; v_mask[1] = 16'hFF00; v_attr[1] = 5'h0C;
        v_base[2] = 16'h4000; v_mask[2] = 16'hC000; v_attr[2] = 5'h15;
        v_base[3] = 16'h8000; v_mask[3] = 16'h8000; v_attr[3] = 5'h1E;
        v_valid = 4'b0111;
        v_ext   = 4'b0100;
        v_sys   = 4'b0001;
        compat_mode = 1'b1;
        par_sel_en  = 1'b1;
        repeat (3) @(negedge clk);
        // R2: reset state
        chk(cs_n == '1 && ale_n && par_bs_n && !aack && !ta && !dval && !ext_bank,
            "R2", "reset outputs", {cs_n, ale_n, par_bs_n, aack, ta, dval, ext_bank}, 0);
        @(posedge clk); #2 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n == '1 && !sys_bus && !attr_vld, "R2", "idle outputs", cs_n, '1);

        // R1 priority (banks 0 and 1 overlap), R3 ALE in compat mode, R9 one lane
        do_xact(16'h1234, 8'hFE, 1'b1, 2, 1'b0);
        // R6/R7/R8 external bank from an internal master
        do_xact(16'h4ABC, 8'h00, 1'b1, 3, 1'b0);
        // R11 miss: bank 3 not yet valid
        do_xact(16'h9000, 8'h00, 1'b1, 1, 1'b0);
        @(negedge clk);
        chk(cs_n == '1 && !ext_bank && ale_n, "R11", "miss stays idle", cs_n, '1);
        // bank 3 enabled, delay 0 treated as 1 (R5), no lane selected (R9)
        v_valid = 4'b1111;
        do_xact(16'h9000, 8'hFF, 1'b0, 0, 1'b0);
        // R3 no ALE out of compat mode, R10 start during busy ignored, R5 long delay
        compat_mode = 1'b0;
        do_xact(16'h1000, 8'h0F, 1'b1, 5, 1'b1);
        // bank 0 disabled: 0x1234 now decodes to bank 1; parity select disabled (R9)
        v_valid    = 4'b1110;
        compat_mode = 1'b1;
        par_sel_en = 1'b0;
        do_xact(16'h1234, 8'h00, 1'b1, 7, 1'b0);
        // R8 external bank from an outside initiator: no attributes
        do_xact(16'h7000, 8'h00, 1'b0, 1, 1'b0);
        // R5 one-cycle delay on bank 3
        par_sel_en = 1'b1;
        do_xact(16'hFFFF, 8'h7F, 1'b1, 1, 1'b0);

        repeat (4) @(negedge clk);
        // R10: every observed transaction was expected and every expected one seen
        chk(n_seen == n_push && q.size() == 0, "R10", "transaction count", n_seen, n_push);
        finish_run();
    end

endmodule